// File: doc/BRIEF.md
# Single-wire slave bit-timing interface

This block sits between a single open-drain data line and the byte-level logic of a slave on a one-wire bus. It runs from the system clock. Every time window is set in microseconds by a parameter and scaled to clock ticks by a ticks-per-microsecond parameter. The line input passes through a synchronizer. The block's only effect on the line is a pull-down enable, which an external open-drain driver turns into a low level.

The block measures how long the line stays low. A long low is a bus reset: the block reports it with a one-cycle strobe and then answers with a timed presence pulse. Every shorter low is a time slot, timed from the master's falling edge. When the upper logic has not armed transmission, the slot is a write slot and the block reports the sampled level as a received bit. When transmission is armed, the slot is a read slot. The block then requests and takes one transmit bit per slot and pulls the line low for the hold window when that bit is 0. Bits are exchanged one per slot, so the upper logic shifts bytes least significant bit first.

Top module: `onewire_slave_phy`

## Requirements
- R1: While and directly after the reset input is asserted, `pull_dn_o`, `rx_valid_o`, `tx_req_o` and `reset_seen_o` are all 0.
- R2: A low level lasting at least RESET_US (480 us) makes `reset_seen_o` high for exactly one cycle, once per low period. A low of 470 us produces no strobe.
- R3: After the line rises at the end of a reset, the block waits PRES_WAIT_US (30 us, inside 15 to 60 us) and then asserts `pull_dn_o` for PRES_LEN_US (120 us, inside 60 to 240 us).
- R4: When `tx_arm_i` is 0 at a falling edge, the line level SAMPLE_US (30 us) after that edge is the received bit. A 1 is reported at the sample point. A 0 is reported once the line rises again. Each report is a one-cycle `rx_valid_o` with the value on `rx_bit_o`.
- R5: When `tx_arm_i` is 1 at a falling edge, `tx_req_o` pulses once and `tx_bit_i` is taken in the cycle before that pulse. A 0 pulls the line low for HOLD_US (30 us) counted from the edge. A 1 leaves the line released.
- R6: Slots started while `tx_arm_i` is 1 never raise `rx_valid_o`.
- R7: A low longer than ABORT_US (120 us) but shorter than a reset produces no bit, no strobe and no presence pulse. The next slot is handled normally.
- R8: A reset that arrives during a slot discards that slot: no bit is reported, and the pull-down is released in the strobe cycle.
- R9: The block's own presence pulse and read hold never count as a slot: they raise neither `rx_valid_o` nor `tx_req_o`. At most one of `rx_valid_o`, `tx_req_o` and `reset_seen_o` is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_i | input | 1 | Sensed level of the open-drain line (1 = released) |
| pull_dn_o | output | 1 | 1 = drive the line low |
| rx_valid_o | output | 1 | One-cycle strobe: a received bit is on rx_bit_o |
| rx_bit_o | output | 1 | Received bit value |
| tx_arm_i | input | 1 | 1 = slots are read slots served from tx_bit_i |
| tx_bit_i | input | 1 | Next bit to transmit |
| tx_req_o | output | 1 | One-cycle strobe: tx_bit_i was taken, present the next bit |
| reset_seen_o | output | 1 | One-cycle strobe: bus reset detected |

## Verification
A wrong slot state shows at the ports within one slot. A missing, duplicated or inverted received bit changes the assembled byte at the end of that byte. A stuck transmit state leaves the line low past the master's sample point, or never pulls it low. A wrong low-duration count shows within one reset: the strobe comes early, comes late or is missing, and the presence delay or width leaves its window, measured in clock ticks from the master's release. Abort handling shows on the next slot, or as a stray presence pulse after a long but sub-reset low.

// File: rtl/owphy_pkg.sv
package owphy_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,    // waiting for a falling edge
    ST_SLOT,    // timing a slot from the falling edge
    ST_RX0,     // zero sampled, waiting for the line to rise
    ST_WAITHI,  // slot done, waiting for released line
    ST_RSTLOW,  // reset seen, waiting for the line to rise
    ST_PWAIT,   // gap before the presence pulse
    ST_PDRV,    // presence pulse driven
    ST_PREL     // presence released, waiting for high line
  } phy_state_t;

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/owphy_sync.sv
module owphy_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bus_i,
  output logic line_o,
  output logic fall_o
);

  logic [STAGES-1:0] chain_q;
  logic              prev_q;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    logic d_in;
    if (g == 0) begin : g_first
      assign d_in = bus_i;
    end else begin : g_next
      assign d_in = chain_q[g-1];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q[g] <= 1'b1;
      else        chain_q[g] <= d_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b1;
    else        prev_q <= chain_q[STAGES-1];
  end

  assign line_o = chain_q[STAGES-1];
  assign fall_o = prev_q & ~chain_q[STAGES-1];

endmodule

// File: rtl/owphy_low_timer.sv
module owphy_low_timer #(
  parameter int RST_T   = 1920,
  parameter int ABORT_T = 480,
  localparam int CW     = $clog2(RST_T + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_i,
  output logic rst_hit_o,
  output logic abort_o
);

  localparam logic [CW-1:0] CMAX  = CW'(RST_T);
  localparam logic [CW-1:0] HIT_V = CW'(RST_T - 1);
  localparam logic [CW-1:0] AB_V  = CW'(ABORT_T);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (line_i)             cnt_d = '0;
    else if (cnt_q != CMAX) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign rst_hit_o = ~line_i & (cnt_q == HIT_V);
  assign abort_o   = ~line_i & (cnt_q >= AB_V);

endmodule

// File: rtl/owphy_slot_fsm.sv
module owphy_slot_fsm
  import owphy_pkg::*;
#(
  parameter int SAMPLE_T = 120,
  parameter int HOLD_T   = 120,
  parameter int PWAIT_T  = 120,
  parameter int PLEN_T   = 480,
  parameter int TW       = 9
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_i,
  input  logic fall_i,
  input  logic rst_hit_i,
  input  logic abort_i,
  input  logic tx_arm_i,
  input  logic tx_bit_i,
  output logic pull_dn_o,
  output logic rx_valid_o,
  output logic rx_bit_o,
  output logic tx_req_o,
  output logic reset_seen_o
);

  localparam logic [TW-1:0] SMP_END  = TW'(SAMPLE_T - 1);
  localparam logic [TW-1:0] HOLD_END = TW'(HOLD_T - 1);
  localparam logic [TW-1:0] PW_END   = TW'(PWAIT_T - 1);
  localparam logic [TW-1:0] PL_END   = TW'(PLEN_T - 1);

  phy_state_t    st_q, st_d;
  logic [TW-1:0] tmr_q, tmr_d;
  logic          mode_q, mode_d;
  logic          pull_q, pull_d;
  logic          rxv_q, rxv_d;
  logic          rxb_q, rxb_d;
  logic          txr_q, txr_d;
  logic          rsts_q, rsts_d;

  always_comb begin
    st_d   = st_q;
    tmr_d  = tmr_q;
    mode_d = mode_q;
    pull_d = 1'b0;
    rxv_d  = 1'b0;
    rxb_d  = rxb_q;
    txr_d  = 1'b0;
    rsts_d = 1'b0;

    case (st_q)
      ST_IDLE: begin
        tmr_d = '0;
        if (fall_i) begin
          st_d   = ST_SLOT;
          mode_d = tx_arm_i;
          if (tx_arm_i) begin
            txr_d  = 1'b1;
            pull_d = ~tx_bit_i;
          end
        end
      end
      ST_SLOT: begin
        tmr_d = tmr_q + 1'b1;
        if (mode_q) begin
          pull_d = pull_q;
          if (tmr_q == HOLD_END) begin
            pull_d = 1'b0;
            st_d   = ST_WAITHI;
          end
        end else if (tmr_q == SMP_END) begin
          if (line_i) begin
            rxv_d = 1'b1;
            rxb_d = 1'b1;
            st_d  = ST_WAITHI;
          end else begin
            st_d  = ST_RX0;
          end
        end
      end
      ST_RX0: begin
        if (abort_i) begin
          st_d = ST_WAITHI;
        end else if (line_i) begin
          rxv_d = 1'b1;
          rxb_d = 1'b0;
          st_d  = ST_IDLE;
        end
      end
      ST_WAITHI: begin
        if (line_i) st_d = ST_IDLE;
      end
      ST_RSTLOW: begin
        tmr_d = '0;
        if (line_i) st_d = ST_PWAIT;
      end
      ST_PWAIT: begin
        tmr_d = tmr_q + 1'b1;
        if (tmr_q == PW_END) begin
          tmr_d  = '0;
          pull_d = 1'b1;
          st_d   = ST_PDRV;
        end
      end
      ST_PDRV: begin
        tmr_d  = tmr_q + 1'b1;
        pull_d = 1'b1;
        if (tmr_q == PL_END) begin
          pull_d = 1'b0;
          st_d   = ST_PREL;
        end
      end
      ST_PREL: begin
        if (line_i) st_d = ST_IDLE;
      end
      default: st_d = ST_IDLE;
    endcase

    if (rst_hit_i) begin
      st_d   = ST_RSTLOW;
      tmr_d  = '0;
      pull_d = 1'b0;
      rxv_d  = 1'b0;
      txr_d  = 1'b0;
      rsts_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      tmr_q  <= '0;
      mode_q <= 1'b0;
      pull_q <= 1'b0;
      rxv_q  <= 1'b0;
      rxb_q  <= 1'b0;
      txr_q  <= 1'b0;
      rsts_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      tmr_q  <= tmr_d;
      mode_q <= mode_d;
      pull_q <= pull_d;
      rxv_q  <= rxv_d;
      rxb_q  <= rxb_d;
      txr_q  <= txr_d;
      rsts_q <= rsts_d;
    end
  end

  assign pull_dn_o    = pull_q;
  assign rx_valid_o   = rxv_q;
  assign rx_bit_o     = rxb_q;
  assign tx_req_o     = txr_q;
  assign reset_seen_o = rsts_q;

endmodule

// File: rtl/onewire_slave_phy.sv
module onewire_slave_phy
  import owphy_pkg::*;
#(
  parameter int TICKS_PER_US = 4,
  parameter int SYNC_STAGES  = 2,
  parameter int RESET_US     = 480,
  parameter int ABORT_US     = 120,
  parameter int SAMPLE_US    = 30,
  parameter int HOLD_US      = 30,
  parameter int PRES_WAIT_US = 30,
  parameter int PRES_LEN_US  = 120
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bus_i,
  output logic pull_dn_o,
  output logic rx_valid_o,
  output logic rx_bit_o,
  input  logic tx_arm_i,
  input  logic tx_bit_i,
  output logic tx_req_o,
  output logic reset_seen_o
);

  localparam int RST_T   = RESET_US * TICKS_PER_US;
  localparam int ABORT_T = ABORT_US * TICKS_PER_US;
  localparam int SMP_T   = SAMPLE_US * TICKS_PER_US;
  localparam int HOLD_T  = HOLD_US * TICKS_PER_US;
  localparam int PW_T    = PRES_WAIT_US * TICKS_PER_US;
  localparam int PL_T    = PRES_LEN_US * TICKS_PER_US;
  localparam int DRV_T   = max2(HOLD_T, PL_T);
  localparam int TMAX    = max2(max2(SMP_T, HOLD_T), max2(PW_T, PL_T));
  localparam int TW      = $clog2(TMAX + 1);

  logic line_s, fall_s, rst_hit_s, abort_s;

  owphy_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .bus_i  (bus_i),
    .line_o (line_s),
    .fall_o (fall_s)
  );

  owphy_low_timer #(.RST_T(RST_T), .ABORT_T(ABORT_T)) u_low (
    .clk       (clk),
    .rst_n     (rst_n),
    .line_i    (line_s),
    .rst_hit_o (rst_hit_s),
    .abort_o   (abort_s)
  );

  owphy_slot_fsm #(
    .SAMPLE_T (SMP_T),
    .HOLD_T   (HOLD_T),
    .PWAIT_T  (PW_T),
    .PLEN_T   (PL_T),
    .TW       (TW)
  ) u_fsm (
    .clk          (clk),
    .rst_n        (rst_n),
    .line_i       (line_s),
    .fall_i       (fall_s),
    .rst_hit_i    (rst_hit_s),
    .abort_i      (abort_s),
    .tx_arm_i     (tx_arm_i),
    .tx_bit_i     (tx_bit_i),
    .pull_dn_o    (pull_dn_o),
    .rx_valid_o   (rx_valid_o),
    .rx_bit_o     (rx_bit_o),
    .tx_req_o     (tx_req_o),
    .reset_seen_o (reset_seen_o)
  );

endmodule

// File: rtl/onewire_slave_phy_chk.sv
module onewire_slave_phy_chk #(
  parameter int RST_TICKS = 1920,
  parameter int DRIVE_MAX = 480
) (
  input logic clk,
  input logic rst_n,
  input logic bus_i,
  input logic pull_dn_o,
  input logic rx_valid_o,
  input logic tx_req_o,
  input logic reset_seen_o
);

  logic [31:0] low_q;
  logic [31:0] drv_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      low_q <= '0;
      drv_q <= '0;
    end else begin
      if (bus_i)                          low_q <= '0;
      else if (low_q < 32'(RST_TICKS + 8)) low_q <= low_q + 1'b1;
      if (!pull_dn_o)                     drv_q <= '0;
      else if (drv_q < 32'(DRIVE_MAX + 8)) drv_q <= drv_q + 1'b1;
    end
  end

  a_r2_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    reset_seen_o |=> !reset_seen_o);

  a_r2_low_long_enough: assert property (@(posedge clk) disable iff (!rst_n)
    reset_seen_o |-> (low_q >= 32'(RST_TICKS)));

  a_r8_quiet_on_reset: assert property (@(posedge clk) disable iff (!rst_n)
    reset_seen_o |-> (!pull_dn_o && !rx_valid_o));

  a_r5_req_single: assert property (@(posedge clk) disable iff (!rst_n)
    tx_req_o |=> !tx_req_o);

  a_r9_one_event: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rx_valid_o, tx_req_o, reset_seen_o}));

  a_r3_drive_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    pull_dn_o |-> (drv_q < 32'(DRIVE_MAX)));

endmodule

bind onewire_slave_phy onewire_slave_phy_chk #(
  .RST_TICKS (RST_T),
  .DRIVE_MAX (DRV_T)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .bus_i        (bus_i),
  .pull_dn_o    (pull_dn_o),
  .rx_valid_o   (rx_valid_o),
  .tx_req_o     (tx_req_o),
  .reset_seen_o (reset_seen_o)
);

// File: tb/sim_onewire_slave_phy.sv
module sim_onewire_slave_phy;

  localparam int CLK_PERIOD = 10;
  localparam int TPU        = 4;
  localparam int PW_TICKS   = 30 * TPU;
  localparam int PL_TICKS   = 120 * TPU;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic master_low = 1'b0;
  logic tx_arm = 1'b0;
  logic [7:0] tx_shift = 8'hFF;
  logic bus;
  logic pull_dn, rx_valid, rx_bit, tx_req, reset_seen;

  int n_chk = 0;
  int n_bad = 0;
  int rx_cnt = 0;
  int rs_cnt = 0;
  int txr_cnt = 0;
  int prise_cnt = 0;
  int rs_long = 0;
  logic rx_last = 1'b0;
  logic [7:0] rx_hist = 8'h00;
  logic pull_prev = 1'b0;
  logic rs_prev = 1'b0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign bus = ~(master_low | pull_dn);

  onewire_slave_phy u0 (
    .clk          (clk),
    .rst_n        (rst_n),
    .bus_i        (bus),
    .pull_dn_o    (pull_dn),
    .rx_valid_o   (rx_valid),
    .rx_bit_o     (rx_bit),
    .tx_arm_i     (tx_arm),
    .tx_bit_i     (tx_shift[0]),
    .tx_req_o     (tx_req),
    .reset_seen_o (reset_seen)
  );

  always @(negedge clk) begin
    if (rst_n) begin
      if (rx_valid) begin
        rx_cnt  <= rx_cnt + 1;
        rx_last <= rx_bit;
        rx_hist <= {rx_bit, rx_hist[7:1]};
      end
      if (reset_seen) rs_cnt <= rs_cnt + 1;
      if (reset_seen && rs_prev) rs_long <= rs_long + 1;
      if (tx_req) txr_cnt <= txr_cnt + 1;
      if (pull_dn && !pull_prev) prise_cnt <= prise_cnt + 1;
      pull_prev <= pull_dn;
      rs_prev   <= reset_seen;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_us(input int n);
    repeat (n * TPU) @(negedge clk);
  endtask

  function automatic int rand_in(input int lo, input int hi);
    return lo + int'($urandom % 32'(hi - lo + 1));
  endfunction

  // R4: one write slot; a 1 is a short low, a 0 a low past the sample point
  task automatic write_slot(input logic b, input int low_us);
    int c0;
    c0 = rx_cnt;
    @(negedge clk);
    master_low = 1'b1;
    wait_us(low_us);
    master_low = 1'b0;
    if (b) wait_us(45 - low_us);
    else   wait_us(10);
    check(rx_cnt == c0 + 1, "R4 bit count", rx_cnt - c0, 1);
    check(rx_last == b, "R4 bit value", int'(rx_last), int'(b));
  endtask

  task automatic write_byte(input logic [7:0] v);
    for (int i = 0; i < 8; i++) begin
      if (v[i]) write_slot(1'b1, rand_in(1, 14));
      else      write_slot(1'b0, rand_in(60, 110));
    end
    check(rx_hist == v, "R4 assembled byte", int'(rx_hist), int'(v));
  endtask

  // R5/R6: master reads a byte, least significant bit first
  task automatic read_byte(input logic [7:0] v);
    logic [7:0] got;
    int c_rx, c_tx;
    c_rx = rx_cnt;
    c_tx = txr_cnt;
    got = 8'h00;
    @(negedge clk);
    tx_arm = 1'b1;
    tx_shift = v;
    for (int i = 0; i < 8; i++) begin
      master_low = 1'b1;
      wait_us(1);
      master_low = 1'b0;
      wait_us(14);
      got[i] = bus;
      wait_us(40);
      tx_shift = {1'b1, tx_shift[7:1]};
    end
    tx_arm = 1'b0;
    check(got == v, "R5 read byte", int'(got), int'(v));
    check(txr_cnt == c_tx + 8, "R5 tx_req count", txr_cnt - c_tx, 8);
    check(rx_cnt == c_rx, "R6 no rx in read slots", rx_cnt - c_rx, 0);
    check(!pull_dn, "R5 line released after hold", int'(pull_dn), 0);
  endtask

  // R2/R3/R9: reset low of low_us, then measure the presence pulse
  task automatic reset_presence(input int low_us, input int rx_exp_delta);
    int c_rs, c_rx, c_tx, d, w;
    c_rs = rs_cnt;
    c_rx = rx_cnt;
    c_tx = txr_cnt;
    @(negedge clk);
    master_low = 1'b1;
    wait_us(low_us);
    check(rs_cnt == c_rs + 1, "R2 reset strobe", rs_cnt - c_rs, 1);
    check(!pull_dn, "R8 no drive during reset", int'(pull_dn), 0);
    master_low = 1'b0;
    d = 0;
    while (!pull_dn && d < 400 * TPU) begin
      @(negedge clk);
      d++;
    end
    w = 0;
    while (pull_dn && w < 400 * TPU) begin
      @(negedge clk);
      w++;
    end
    check(d >= 15 * TPU && d <= 60 * TPU && d >= PW_TICKS && d <= PW_TICKS + 4,
          "R3 presence delay ticks", d, PW_TICKS + 3);
    check(w >= 60 * TPU && w <= 240 * TPU && w >= PL_TICKS - 1 && w <= PL_TICKS + 1,
          "R3 presence width ticks", w, PL_TICKS);
    wait_us(10);
    check(rx_cnt == c_rx + rx_exp_delta, "R9 presence gives no bit", rx_cnt - c_rx, rx_exp_delta);
    check(txr_cnt == c_tx, "R9 presence gives no tx_req", txr_cnt - c_tx, 0);
    check(rs_long == 0, "R2 strobe one cycle", rs_long, 0);
  endtask

  // R7: long low below the reset length
  task automatic abort_low(input int low_us);
    int c_rs, c_rx, c_p;
    c_rs = rs_cnt;
    c_rx = rx_cnt;
    c_p  = prise_cnt;
    @(negedge clk);
    master_low = 1'b1;
    wait_us(low_us);
    master_low = 1'b0;
    wait_us(300);
    check(rs_cnt == c_rs, "R7 R2 no strobe below reset length", rs_cnt - c_rs, 0);
    check(rx_cnt == c_rx, "R7 no bit from aborted slot", rx_cnt - c_rx, 0);
    check(prise_cnt == c_p, "R7 no presence after abort", prise_cnt - c_p, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (5) @(negedge clk);
    // R1 during reset
    check(!pull_dn && !rx_valid && !tx_req && !reset_seen, "R1 outputs in reset",
          int'({pull_dn, rx_valid, tx_req, reset_seen}), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(!pull_dn && !rx_valid && !tx_req && !reset_seen, "R1 outputs after reset",
          int'({pull_dn, rx_valid, tx_req, reset_seen}), 0);
    wait_us(5);

    reset_presence(485, 0);
    write_byte(8'hA5);
    read_byte(8'h3C);
    write_byte(8'h00);
    write_byte(8'hFF);
    read_byte(8'h01);
    read_byte(8'h80);

    // R7 boundary just below reset length, then normal traffic
    abort_low(470);
    write_slot(1'b0, 100);
    abort_low(200);
    write_byte(8'h5A);

    // R8 reset arriving in a write slot: no bit, strobe and presence
    reset_presence(1000, 0);
    read_byte(8'hC3);

    for (int k = 0; k < 5; k++) begin
      write_byte(8'($urandom));
      read_byte(8'($urandom));
      if (($urandom % 2) == 0) reset_presence(rand_in(485, 900), 0);
    end

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule